// File: doc/BRIEF.md
# Time-Base Counter with Watchdog Supervisor

This block runs a free-running binary time base and uses it to supervise software. Other timers in the chip can tap the counter value from the `tb_count` output. A watchdog sits on top of the counter. It stays dormant after reset until software writes the watchdog control register for the first time. That first write switches the watchdog on and fixes its interval from a two-bit code. Once armed, the watchdog cannot be switched off, and only the external reset input returns it to the dormant state.

Software keeps the watchdog alive by writing a two-byte unlock pair to a separate clear register: 0xA5 first, then 0x5A on the next write. A complete pair clears the pending-timeout flag and zeroes the counter. If software stops doing this, the first falling edge of the selected counter bit sets the flag. The next falling edge, with the flag still set, produces a one-cycle reset request towards the system reset controller. The delay from the last keep-alive to the request is therefore about two periods of the selected bit.

Top module: `tbw_supervisor`

## Requirements
- R1: After reset, `tb_count` is zero. On every clock it increases by one, wrapping modulo 2^CNT_W, except in the cycle after a keep-alive completes.
- R2: The first write to address CTRL_ADDR after reset arms the watchdog and latches the interval code from `wr_data[9:8]`.
- R3: Interval code k selects counter bit CNT_W-7+2k. With the default width of 26, this is bit 19, 21, 23 or 25.
- R4: After the watchdog is armed, further writes to CTRL_ADDR change neither the interval code nor the armed state.
- R5: A write of 0xA5 to CLR_ADDR (`wr_data[7:0]`), followed directly by a write of 0x5A to CLR_ADDR, completes a keep-alive. The 0x5A write may come in the next cycle or later, but with no other CLR_ADDR write between the two. A completed keep-alive clears the timeout flag, and `tb_count` reads zero in the following cycle.
- R6: While the watchdog is armed, a falling edge of the selected counter bit sets the timeout flag.
- R7: If a falling edge of the selected bit arrives while the flag is set, `wd_reset_req` rises one clock later. Measured from a keep-alive at count zero, this happens 2^(bit+2)+1 clocks later.
- R8: While unarmed, the block never raises `wd_reset_req`. Asserting `rst_n` returns the block to the unarmed state.
- R9: A write of 0x5A to CLR_ADDR that does not directly follow a 0xA5 has no effect and resets the sequence tracker. The same holds for a write of any value other than 0xA5 or 0x5A.
- R10: `wd_reset_req` is high for exactly one clock per request.
- R11: Zeroing the counter on a keep-alive while the selected bit is 1 does not count as a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System base clock |
| rst_n | input | 1 | Active-low asynchronous reset; clears counter and disarms |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| tb_count | output | CNT_W | Current time-base counter value |
| wd_reset_req | output | 1 | One-cycle reset request on watchdog timeout |

## Verification
The hardest state to reach is a keep-alive that zeroes the counter while the selected bit is high and the timeout flag is already set. That situation exposes both a flag that fails to clear and a spurious falling edge caused by the clear. The bench builds this state with a narrowed counter. It waits on `tb_count` until the flag has certainly been set, then times the unlock pair so that the second byte lands on a count where the tap bit is 1. It then measures the clocks to the request from that point. A request after 17 clocks instead of 33 reveals either fault.

// File: rtl/tbw_pkg.sv
package tbw_pkg;
  localparam int unsigned NUM_CODES = 4;
  localparam logic [7:0] UNLOCK_FIRST  = 8'hA5;
  localparam logic [7:0] UNLOCK_SECOND = 8'h5A;

  // R3: counter bit watched for interval code k
  function automatic int unsigned tap_of(input int unsigned cnt_w, input int unsigned code);
    return cnt_w - 7 + 2 * code;
  endfunction
endpackage

// File: rtl/tbw_counter.sv
module tbw_counter #(
  parameter int unsigned CNT_W = 26
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zero_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (zero_i) cnt_o <= '0;
    else             cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/tbw_arm.sv
module tbw_arm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr_i,
  input  logic [1:0] code_i,
  output logic       armed_o,
  output logic [1:0] code_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_o <= 1'b0;
      code_o  <= 2'd0;
    end else if (ctrl_wr_i && !armed_o) begin
      armed_o <= 1'b1;
      code_o  <= code_i;
    end
  end
endmodule

// File: rtl/tbw_unlock.sv
module tbw_unlock
  import tbw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_wr_i,
  input  logic [7:0] byte_i,
  output logic       kick_o
);
  logic first_seen;
  logic is_first;
  logic is_second;

  assign is_first  = (byte_i == UNLOCK_FIRST);
  assign is_second = (byte_i == UNLOCK_SECOND);
  assign kick_o    = clr_wr_i && is_second && first_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        first_seen <= 1'b0;
    else if (clr_wr_i) first_seen <= is_first;
  end
endmodule

// File: rtl/tbw_timeout.sv
module tbw_timeout (
  input  logic clk,
  input  logic rst_n,
  input  logic armed_i,
  input  logic tap_i,
  input  logic kick_i,
  output logic fall_o,
  output logic flag_o,
  output logic req_o
);
  logic tap_q;

  assign fall_o = armed_i && tap_q && !tap_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_q  <= 1'b0;
      flag_o <= 1'b0;
      req_o  <= 1'b0;
    end else begin
      tap_q <= kick_i ? 1'b0 : tap_i;
      if (kick_i)      flag_o <= 1'b0;
      else if (fall_o) flag_o <= 1'b1;
      req_o <= fall_o && flag_o && !kick_i;
    end
  end
endmodule

// File: rtl/tbw_supervisor.sv
module tbw_supervisor
  import tbw_pkg::*;
#(
  parameter int unsigned CNT_W    = 26,
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DATA_W   = 16,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'd0,
  parameter logic [ADDR_W-1:0] CLR_ADDR  = 'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  tb_count,
  output logic              wd_reset_req
);
  logic ctrl_wr, clr_wr;
  logic kick, armed, fall, flag, tap_bit;
  logic [1:0] code;
  logic [NUM_CODES-1:0] taps;
  logic unused_hi;

  assign ctrl_wr   = wr_en && (wr_addr == CTRL_ADDR);
  assign clr_wr    = wr_en && (wr_addr == CLR_ADDR);
  assign unused_hi = ^wr_data[DATA_W-1:10];

  tbw_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .zero_i(kick), .cnt_o(tb_count)
  );

  tbw_arm u_arm (
    .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr),
    .code_i(wr_data[9:8]), .armed_o(armed), .code_o(code)
  );

  tbw_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .clr_wr_i(clr_wr),
    .byte_i(wr_data[7:0]), .kick_o(kick)
  );

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_tap
    assign taps[g] = tb_count[tap_of(CNT_W, g)];
  end
  assign tap_bit = taps[code];

  tbw_timeout u_to (
    .clk(clk), .rst_n(rst_n), .armed_i(armed), .tap_i(tap_bit),
    .kick_i(kick), .fall_o(fall), .flag_o(flag), .req_o(wd_reset_req)
  );
endmodule

// File: rtl/tbw_checker.sv
module tbw_checker #(
  parameter int unsigned CNT_W = 26
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             armed,
  input logic             flag,
  input logic             fall,
  input logic             kick,
  input logic [1:0]       code,
  input logic [CNT_W-1:0] cnt
);
  a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    !kick |=> cnt == $past(cnt) + 1'b1);
  a_r5_kick_clears: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt == '0) && !flag);
  a_r4_code_locked: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> armed && $stable(code));
  a_r6_flag_from_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(fall));
  a_r7_req_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    req |-> flag);
  a_r8_unarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !req);
  a_r10_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> !req);
endmodule

bind tbw_supervisor tbw_checker #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(wd_reset_req), .armed(armed), .flag(flag),
  .fall(fall), .kick(kick), .code(code), .cnt(tb_count)
);

// File: tb/tbw_supervisor_tb_top.sv
module tbw_supervisor_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned CNT_W = 10;
  localparam logic [3:0] A_CTRL = 4'd0;
  localparam logic [3:0] A_CLR  = 4'd1;
  localparam logic [3:0] A_OTHER = 4'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [CNT_W-1:0] tb_count;
  logic wd_reset_req;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbw_supervisor #(.CNT_W(CNT_W), .CTRL_ADDR(A_CTRL), .CLR_ADDR(A_CLR)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .tb_count(tb_count), .wd_reset_req(wd_reset_req)
  );

  // Expected clocks from keep-alive at count zero to the request
  function automatic int req_delay(input int code);
    int bitpos;
    bitpos = int'(CNT_W) - 7 + 2 * code;
    return (1 << (bitpos + 2)) + 1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wr_en = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic keep_alive();
    wr(A_CLR, 16'h00A5);
    wr(A_CLR, 16'h005A);
  endtask

  task automatic wait_count(input int v);
    while (int'(tb_count) != v) @(negedge clk);
  endtask

  // Count clocks to the request; also checks the pulse width
  task automatic measure(input int exp, input string tag);
    int n = 0;
    while (!wd_reset_req && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(n == exp, tag, n, exp);
    @(negedge clk);
    check(!wd_reset_req, "R10 pulse width", int'(wd_reset_req), 0);
  endtask

  task automatic t_reset_state();
    do_reset();
    check(tb_count == 0, "R1 reset count", int'(tb_count), 0);
    check(!wd_reset_req, "R1 reset req", int'(wd_reset_req), 0);
    repeat (5) @(negedge clk);
    check(tb_count == 5, "R1 increment", int'(tb_count), 5);
  endtask

  task automatic t_intervals();
    for (int c = 0; c < 4; c++) begin
      do_reset();
      wr(A_CTRL, 16'(c << 8));
      keep_alive();
      check(tb_count == 0, "R5 count zeroed", int'(tb_count), 0);
      measure(req_delay(c), $sformatf("R3 R6 R7 code %0d", c));
    end
  endtask

  task automatic t_write_once();
    do_reset();
    wr(A_CTRL, 16'h0000);
    wr(A_CTRL, 16'h0300);
    keep_alive();
    measure(req_delay(0), "R4 interval locked");
    do_reset();
    wr(A_CTRL, 16'h0100);
    wr(A_CTRL, 16'h0000);
    keep_alive();
    measure(req_delay(1), "R2 R4 first write wins");
  endtask

  task automatic t_unarmed();
    int seen = 0;
    do_reset();
    for (int i = 0; i < 2600; i++) begin
      @(negedge clk);
      if (wd_reset_req) seen++;
    end
    check(seen == 0, "R8 unarmed no request", seen, 0);
    wr(A_CTRL, 16'h0000);
    do_reset();
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (wd_reset_req) seen++;
    end
    check(seen == 0, "R8 reset disarms", seen, 0);
  endtask

  task automatic t_keep_alive();
    int seen = 0;
    do_reset();
    wr(A_CTRL, 16'h0000);
    keep_alive();
    for (int k = 0; k < 10; k++) begin
      repeat (20) @(negedge clk);
      if (wd_reset_req) seen++;
      keep_alive();
      if (wd_reset_req) seen++;
    end
    check(seen == 0, "R5 regular keep-alive", seen, 0);
    // flag is set once count passes 16; land the 0x5A on count 28 (tap bit 1)
    wait_count(27);
    wr(A_CLR, 16'h00A5);
    check(tb_count == 28, "R11 setup count", int'(tb_count), 28);
    wr(A_CLR, 16'h005A);
    measure(req_delay(0), "R5 R11 flag cleared, no false edge");
  endtask

  task automatic t_bad_sequences();
    do_reset();
    wr(A_CTRL, 16'h0000);
    keep_alive();
    wait_count(5);
    wr(A_CLR, 16'h005A);
    check(tb_count == 6, "R9 lone 5A ignored", int'(tb_count), 6);
    wr(A_CLR, 16'h00A5);
    wr(A_CLR, 16'h0033);
    wr(A_CLR, 16'h005A);
    check(tb_count == 9, "R9 broken pair ignored", int'(tb_count), 9);
    wr(A_CLR, 16'h00A5);
    wr(A_OTHER, 16'h005A);
    check(tb_count == 11, "R9 other address ignored", int'(tb_count), 11);
    measure(req_delay(0) - 11, "R9 flag untouched");
  endtask

  initial begin
    t_reset_state();
    t_intervals();
    t_write_once();
    t_unarmed();
    t_keep_alive();
    t_bad_sequences();
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) check(1'b0, "watchdog expired", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule